// File: doc/BRIEF.md
# Paged PHY Register Access Sequencer

This block sits on the management side of an Ethernet PHY. It turns one request for a register that lives in a banked (paged) vendor area into a short, uninterrupted series of plain register transactions. The transactions go out on a downstream request/acknowledge port that carries one Clause 22 register read or write at a time. Serial frame generation happens beyond that port.

A request names the PHY address, the register number, the page that register lives on, the write data, and whether it is a read or a write. For a vendor register (number 16 or above), the sequencer first reads the page-select register to learn which bank is live. It selects the wanted bank only if that bank is not already live. It then performs the access, and finally writes the original bank number back if it changed it. Registers 0 to 15 are standard and not banked, so they get a single direct transaction. The whole series runs under an exclusive grant from a bus arbiter, so no other master can slip a transaction into the middle of it. The number of the page-select register is an input, so one design serves PHYs that bank through different registers.

Top module: `paged_phy_seq`

## Requirements
- R1: After reset, `busy`, `done`, `lock_req` and `mgmt_req` are all 0.
- R2: A request with `req_valid` high while idle is taken at that clock edge. From the next cycle `busy` and `lock_req` are 1. No transaction is issued before `lock_gnt` is seen high.
- R3: For a register number of 16 or more whose page differs from the current one, exactly four transactions go out, all to `req_phy`, in this order: read of `sel_reg`; write of `sel_reg` with the requested page; the access to the target register; write of `sel_reg` with the page value the first read returned.
- R4: The access transaction has `mgmt_write` equal to `req_write`. For a write, `mgmt_wdata` on the access equals `req_wdata`.
- R5: For a read request, `rdata` holds the data returned by the access transaction while `done` is high.
- R6: For a register number of 16 or more whose requested page equals the value read from `sel_reg`, exactly two transactions go out: the page read and the access. The page is left unchanged.
- R7: For a register number below 16, exactly one transaction goes out: the access itself. No page-select transaction is made.
- R8: `mgmt_req` is high only while `lock_req` is high. `lock_req` stays high until the last transaction of the series is acknowledged and is low while `done` is high.
- R9: `done` is high for exactly one cycle per request, and `busy` is 0 in the cycle after `done`.
- R10: A `req_valid` pulse while `busy` is high is ignored. It adds no transaction and starts no second series.
- R11: While `mgmt_req` is high and not yet acknowledged, the transaction fields stay stable into the next cycle and `mgmt_req` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register number |
| req_page | input | 16 | Bank that holds the target register |
| req_wdata | input | 16 | Data for a write |
| sel_reg | input | 5 | Number of the page-select register |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Data from the last read access |
| lock_req | output | 1 | Exclusive bus ownership request to the arbiter |
| lock_gnt | input | 1 | Ownership granted |
| mgmt_req | output | 1 | Downstream transaction request |
| mgmt_write | output | 1 | Downstream transaction is a write |
| mgmt_phy | output | 5 | Downstream PHY address |
| mgmt_reg | output | 5 | Downstream register number |
| mgmt_wdata | output | 16 | Downstream write data |
| mgmt_ack | input | 1 | Downstream transaction complete |
| mgmt_rdata | input | 16 | Downstream read data, valid with `mgmt_ack` |

## Verification
Requests are drawn from three groups:
- Vendor registers on a bank other than the live one. These must give the full four-step series, which separates a correct bank restore from one that leaves the wrong bank live.
- Vendor registers on the bank already live. These must skip the select and restore writes, and the transaction count separates the two cases.
- Standard registers. These must bypass paging entirely.

The PHY model holds separate contents per bank. A read after a write on the same bank and register returns the written value only if the right bank was selected, while a read on another bank returns that bank's original content. Arbiter and acknowledge latencies are varied per request, and a request pulsed in mid-series shows whether the block ignores it while busy.

// File: rtl/paged_phy_seq.sv
module paged_phy_seq #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int STD_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_page,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] sel_reg,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              lock_req,
  input  logic              lock_gnt,
  output logic              mgmt_req,
  output logic              mgmt_write,
  output logic [ADDR_W-1:0] mgmt_phy,
  output logic [ADDR_W-1:0] mgmt_reg,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic [DATA_W-1:0] mgmt_rdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOCK, S_RDPG, S_SETPG, S_ACC, S_REST, S_DONE
  } st_t;

  localparam logic [ADDR_W-1:0] FIRST_VENDOR = ADDR_W'(STD_REGS);

  st_t               st;
  logic              q_wr;
  logic              need_rest;
  logic [ADDR_W-1:0] q_phy, q_reg, q_sel;
  logic [DATA_W-1:0] q_page, q_wdata, orig_page, rdata_q;

  wire paged = (q_reg >= FIRST_VENDOR);

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign rdata      = rdata_q;
  assign lock_req   = (st != S_IDLE) && (st != S_DONE);
  assign mgmt_req   = (st == S_RDPG) || (st == S_SETPG) || (st == S_ACC) || (st == S_REST);
  assign mgmt_write = (st == S_SETPG) || (st == S_REST) || ((st == S_ACC) && q_wr);
  assign mgmt_phy   = q_phy;
  assign mgmt_reg   = (st == S_ACC) ? q_reg : q_sel;
  assign mgmt_wdata = (st == S_SETPG) ? q_page :
                      (st == S_REST)  ? orig_page : q_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      q_wr      <= 1'b0;
      q_phy     <= '0;
      q_reg     <= '0;
      q_sel     <= '0;
      q_page    <= '0;
      q_wdata   <= '0;
      orig_page <= '0;
      rdata_q   <= '0;
      need_rest <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          q_wr      <= req_write;
          q_phy     <= req_phy;
          q_reg     <= req_reg;
          q_sel     <= sel_reg;
          q_page    <= req_page;
          q_wdata   <= req_wdata;
          need_rest <= 1'b0;
          st        <= S_LOCK;
        end
        S_LOCK: if (lock_gnt) st <= paged ? S_RDPG : S_ACC;
        S_RDPG: if (mgmt_ack) begin
          orig_page <= mgmt_rdata;
          need_rest <= (mgmt_rdata != q_page);
          st        <= (mgmt_rdata != q_page) ? S_SETPG : S_ACC;
        end
        S_SETPG: if (mgmt_ack) st <= S_ACC;
        S_ACC: if (mgmt_ack) begin
          if (!q_wr) rdata_q <= mgmt_rdata;
          st <= need_rest ? S_REST : S_DONE;
        end
        S_REST: if (mgmt_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_req_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |-> lock_req);

  a_r8_lock_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lock_req);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_reg) && $stable(mgmt_write)
                                 && $stable(mgmt_wdata) && $stable(mgmt_phy)));

  a_r2_take_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (busy && lock_req));

  a_r2_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_req && !mgmt_req && !lock_gnt) |=> !mgmt_req);

endmodule

// File: tb/sim_paged_phy_seq.sv
module sim_paged_phy_seq;
  localparam logic [4:0] SEL = 5'd31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [4:0] req_phy = 0, req_reg = 0;
  logic [15:0] req_page = 0, req_wdata = 0;
  logic busy, done, lock_req, mgmt_req, mgmt_write;
  logic [15:0] rdata, mgmt_wdata;
  logic [4:0] mgmt_phy, mgmt_reg;
  logic lock_gnt = 0, mgmt_ack = 0;
  logic [15:0] mgmt_rdata = 0;

  paged_phy_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_page(req_page), .req_wdata(req_wdata),
    .sel_reg(SEL), .busy(busy), .done(done), .rdata(rdata), .lock_req(lock_req),
    .lock_gnt(lock_gnt), .mgmt_req(mgmt_req), .mgmt_write(mgmt_write),
    .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
    .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata)
  );

  int checks = 0, errors = 0;
  int cycles = 0;

  // PHY and arbiter model, all updates on the falling edge
  logic [15:0] cur_page = 0;
  logic [15:0] vmem [4][16];
  logic [15:0] smem [16];
  int lat = 0, glat = 0, acnt = 0, gcnt = 0;
  logic set_pg = 0;
  logic [15:0] set_val = 0;
  int nlog = 0;
  logic       log_w [8];
  logic [4:0] log_r [8];
  logic [4:0] log_p [8];
  logic [15:0] log_d [8];
  int lockless = 0;

  initial begin
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 16; r++) vmem[p][r] = {4'hA, 2'b00, 2'(p), 3'b000, 5'(r + 16)};
    for (int r = 0; r < 16; r++) smem[r] = {8'h5C, 3'b000, 5'(r)};
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (mgmt_req && !lock_gnt) lockless <= lockless + 1;
    if (set_pg) cur_page <= set_val;
    if (!lock_req) begin lock_gnt <= 0; gcnt <= 0; end
    else if (!lock_gnt) begin
      if (gcnt >= glat) lock_gnt <= 1; else gcnt <= gcnt + 1;
    end
    if (mgmt_ack) begin mgmt_ack <= 0; acnt <= 0; end
    else if (mgmt_req) begin
      if (acnt >= lat) begin
        mgmt_ack <= 1;
        if (nlog < 8) begin
          log_w[nlog] <= mgmt_write; log_r[nlog] <= mgmt_reg;
          log_p[nlog] <= mgmt_phy;   log_d[nlog] <= mgmt_wdata;
        end
        nlog <= nlog + 1;
        if (mgmt_write) begin
          if (mgmt_reg == SEL) cur_page <= mgmt_wdata;
          else if (mgmt_reg < 16) smem[mgmt_reg[3:0]] <= mgmt_wdata;
          else vmem[cur_page[1:0]][mgmt_reg[3:0]] <= mgmt_wdata;
        end else begin
          if (mgmt_reg == SEL) mgmt_rdata <= cur_page;
          else if (mgmt_reg < 16) mgmt_rdata <= smem[mgmt_reg[3:0]];
          else mgmt_rdata <= vmem[cur_page[1:0]][mgmt_reg[3:0]];
        end
      end else acnt <= acnt + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog run did not end actual=%0d expected=0", cycles);
    finish_run();
  end

  typedef struct packed {
    logic        wr;
    logic [4:0]  rg;
    logic [1:0]  pg;
    logic [1:0]  ipg;
    logic [15:0] wd;
    logic [3:0]  lat;
    logic [3:0]  glat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd17, 2'd1, 2'd0, 16'h0000, 4'd0, 4'd0},
    '{1'b1, 5'd18, 2'd1, 2'd0, 16'hBEEF, 4'd1, 4'd2},
    '{1'b0, 5'd18, 2'd1, 2'd0, 16'h0000, 4'd2, 4'd0},
    '{1'b0, 5'd18, 2'd2, 2'd0, 16'h0000, 4'd0, 4'd1},
    '{1'b0, 5'd20, 2'd0, 2'd0, 16'h0000, 4'd1, 4'd0},
    '{1'b1, 5'd20, 2'd3, 2'd3, 16'h1234, 4'd0, 4'd3},
    '{1'b0, 5'd20, 2'd3, 2'd1, 16'h0000, 4'd3, 4'd0},
    '{1'b0, 5'd3,  2'd2, 2'd1, 16'h0000, 4'd0, 4'd0},
    '{1'b1, 5'd5,  2'd0, 2'd2, 16'h0F0F, 4'd2, 4'd1},
    '{1'b0, 5'd5,  2'd0, 2'd2, 16'h0000, 4'd0, 4'd0},
    '{1'b1, 5'd30, 2'd2, 2'd3, 16'h5A5A, 4'd3, 4'd5},
    '{1'b0, 5'd30, 2'd2, 2'd2, 16'h0000, 4'd1, 4'd0}
  };

  logic [15:0] evmem [4][16];
  logic [15:0] esmem [16];

  task automatic pulse_req(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] pg, input logic [15:0] wd);
    req_valid = 1; req_write = wr; req_phy = phy; req_reg = rg; req_page = pg; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output bit seen, output logic [15:0] rd);
    seen = 0; rd = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (done) begin seen = 1; rd = rdata; end
      else @(negedge clk);
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    bit seen;
    logic [15:0] rd, expd;
    int nexp;
    logic [4:0] phy;
    phy = 5'(idx + 1);
    @(negedge clk);
    set_pg = 1; set_val = {14'd0, v.ipg};
    @(negedge clk);
    set_pg = 0; lat = v.lat; glat = v.glat; nlog = 0;
    pulse_req(v.wr, phy, v.rg, {14'd0, v.pg}, v.wd);
    chk(busy && lock_req, "R2", $sformatf("v%0d busy/lock after take", idx), {busy, lock_req}, 2'b11);
    wait_done(seen, rd);
    chk(seen, "R9", $sformatf("v%0d done seen", idx), seen, 1);
    chk(!lock_req, "R8", $sformatf("v%0d lock released at done", idx), lock_req, 0);
    if (v.rg < 16) begin
      nexp = 1;
      expd = esmem[v.rg[3:0]];
      if (v.wr) esmem[v.rg[3:0]] = v.wd;
    end else begin
      nexp = (v.pg == v.ipg) ? 2 : 4;
      expd = evmem[v.pg][v.rg[3:0]];
      if (v.wr) evmem[v.pg][v.rg[3:0]] = v.wd;
    end
    @(negedge clk);
    chk(!done && !busy, "R9", $sformatf("v%0d done single cycle", idx), {done, busy}, 0);
    chk(nlog == nexp, v.rg < 16 ? "R7" : (nexp == 2 ? "R6" : "R3"),
        $sformatf("v%0d transaction count", idx), nlog, nexp);
    if (nlog == nexp) begin
      for (int k = 0; k < nexp; k++)
        chk(log_p[k] == phy, "R3", $sformatf("v%0d tx%0d phy", idx, k), log_p[k], phy);
      if (nexp >= 2) begin
        chk(!log_w[0] && log_r[0] == SEL, "R3", $sformatf("v%0d page read", idx),
            {log_w[0], log_r[0]}, {1'b0, SEL});
      end
      if (nexp == 4) begin
        chk(log_w[1] && log_r[1] == SEL && log_d[1] == {14'd0, v.pg}, "R3",
            $sformatf("v%0d page select", idx), log_d[1], {14'd0, v.pg});
        chk(log_w[3] && log_r[3] == SEL && log_d[3] == {14'd0, v.ipg}, "R3",
            $sformatf("v%0d page restore", idx), log_d[3], {14'd0, v.ipg});
      end
      chk(log_w[nexp-2 < 0 ? 0 : (nexp == 4 ? 2 : nexp - 1)] == v.wr &&
          log_r[nexp == 4 ? 2 : nexp - 1] == v.rg, "R4",
          $sformatf("v%0d access kind/reg", idx),
          {log_w[nexp == 4 ? 2 : nexp - 1], log_r[nexp == 4 ? 2 : nexp - 1]}, {v.wr, v.rg});
      if (v.wr)
        chk(log_d[nexp == 4 ? 2 : nexp - 1] == v.wd, "R4", $sformatf("v%0d write data", idx),
            log_d[nexp == 4 ? 2 : nexp - 1], v.wd);
    end
    if (!v.wr) chk(rd == expd, "R5", $sformatf("v%0d read data", idx), rd, expd);
    chk(cur_page == {14'd0, v.ipg}, nexp == 2 ? "R6" : "R3",
        $sformatf("v%0d live page after", idx), cur_page, {14'd0, v.ipg});
  endtask

  initial begin
    bit seen;
    logic [15:0] rd;
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 16; r++) evmem[p][r] = {4'hA, 2'b00, 2'(p), 3'b000, 5'(r + 16)};
    for (int r = 0; r < 16; r++) esmem[r] = {8'h5C, 3'b000, 5'(r)};

    repeat (3) @(negedge clk);
    chk(!busy && !done && !lock_req && !mgmt_req, "R1", "state in reset",
        {busy, done, lock_req, mgmt_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !lock_req && !mgmt_req, "R1", "state after reset",
        {busy, done, lock_req, mgmt_req}, 0);

    for (int i = 0; i < NV; i++) run_vec(i, VEC[i]);

    // R2: no transaction before grant, long arbiter delay
    @(negedge clk);
    set_pg = 1; set_val = 16'd0;
    @(negedge clk);
    set_pg = 0; lat = 1; glat = 12; nlog = 0;
    pulse_req(1'b0, 5'd9, 5'd17, 16'd2, 16'd0);
    repeat (8) @(negedge clk);
    chk(nlog == 0 && !mgmt_req, "R2", "no transaction before grant", nlog, 0);
    // R10: second request while busy is ignored
    pulse_req(1'b1, 5'd9, 5'd3, 16'd0, 16'hDEAD);
    wait_done(seen, rd);
    chk(seen && rd == evmem[2][1], "R5", "read after long grant", rd, evmem[2][1]);
    @(negedge clk);
    chk(nlog == 4, "R10", "ignored request adds no transaction", nlog, 4);
    repeat (4) @(negedge clk);
    chk(!busy && nlog == 4, "R10", "no second series started", {busy, 8'(nlog)}, 4);
    chk(smem[3] == esmem[3], "R10", "ignored write left register intact", smem[3], esmem[3]);
    chk(lockless == 0, "R8", "transactions outside grant", lockless, 0);

    finish_run();
  end
endmodule